// File: doc/BRIEF.md
# Serial Two-Wire Byte Memory Target

This block is the bus side of a 2048-byte serial memory. It behaves as a target on a two-wire I2C bus. The block runs on a fast system clock and oversamples the SCL and SDA lines through synchronizers. It finds START and STOP conditions and matches the device byte. It then moves bytes in and out, one bit per SCL pulse, with an acknowledge on the ninth pulse. The pad is modelled as open drain. When `sda_oe_o` is high, the pad must pull SDA low. When it is low, SDA is released.

Each write transaction places bytes in a 16-entry page buffer. The buffer is copied into the array only when STOP arrives. After that copy, the block stays deaf to its address for a programmable number of clocks, so a host can poll for completion. A write-protect input refuses data bytes. A disable input, meant to be driven by a system reset monitor, blocks every access.

The controller is one state machine with these states:
- `ST_IDLE`
- `ST_DEVADDR` (device byte reception)
- `ST_DEV_ACK`
- `ST_WORD` (word address reception)
- `ST_WORD_ACK`
- `ST_WDATA` (write data reception)
- `ST_WDATA_ACK`
- `ST_RDATA` (read byte transmission)
- `ST_RD_ACK` (master acknowledge sampling)
- `ST_WAIT_STOP`

The transitions are:
- START moves any state to `ST_DEVADDR`.
- STOP moves any state to `ST_IDLE`.
- The disable input moves any state to `ST_IDLE` and takes priority over both.
- In `ST_DEVADDR`, the eighth SCL fall moves to `ST_DEV_ACK` on a match and to `ST_IDLE` otherwise.
- `ST_DEV_ACK` moves to `ST_RDATA` for a read and to `ST_WORD` for a write.
- `ST_WORD` moves to `ST_WORD_ACK`, which moves to `ST_WDATA`.
- `ST_WDATA` moves to `ST_WDATA_ACK`, or to `ST_IDLE` when write protect is high. `ST_WDATA_ACK` moves back to `ST_WDATA`.
- `ST_RDATA` moves to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` moves to `ST_RDATA` on a master ACK and to `ST_WAIT_STOP` on a NACK.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A START is a falling SDA while SCL is high, and a STOP is a rising SDA while SCL is high. Bytes clocked without a preceding START are never acknowledged.
- R2: The device byte carries fixed bits 1010 in bits 7..4, address bits a10..a8 in bits 3..1, and R/W in bit 0 (1 = read). On a mismatch, the target gives no acknowledge and ignores the bus until the next START.
- R3: The target drives `sda_oe_o`=1 (SDA low) during the ninth clock after three kinds of byte: a matched device byte, the word-address byte, and each accepted write data byte.
- R4: Each accepted write data byte advances only the low 4 bits of the address pointer. The 17th and later bytes of a burst therefore overwrite earlier bytes of the same 16-byte page.
- R5: Buffered write data reaches the array only at STOP. A START in mid-transaction discards the buffer and restarts device-byte reception.
- R6: For BUSY_CYCLES clocks after a STOP that commits data, the device byte is not acknowledged. After that window it is acknowledged again.
- R7: Every matched device byte loads a10..a8 into the pointer.
  - Reads advance the full 11-bit pointer, and 2047 wraps to 0.
  - A read with no word address starts at the last accessed address plus one.
- R8: A random read is a write-type device byte, then a word address, a repeated START and a read device byte. It returns the byte at the given address.
- R9: After a read byte, a master ACK (SDA low) causes the next byte to be sent. A master NACK makes the target release SDA until the next START or STOP.
- R10: With `wp_i` high, the device byte and the word byte are acknowledged. The first data byte is not acknowledged, the array is unchanged, and no busy window follows.
- R11: While `dis_i` is high, the target acknowledges nothing and abandons any transaction with its buffer discarded.
- R12: `sda_oe_o` changes only while SCL is low.
- R13: After reset, `sda_oe_o` is 0, the pointer is 0 and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the wire |
| wp_i | input | 1 | Write protect; high refuses data bytes |
| dis_i | input | 1 | Access disable from the reset monitor; high blocks the bus side |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The bench builds the block with BUSY_CYCLES set to 400 and keeps the default 16-byte page, 2048-byte array and two-stage synchronizers. With the short busy window, acknowledge polling fits inside one run. One poll is refused while the window is open and a later poll is answered after it closes. With the full-size array, the pointer wrap from 2047 to 0 and the page wrap after 16 bytes are both exercised. A byte-level reference model in the bench predicts every acknowledge and every read byte. A per-clock monitor watches when `sda_oe_o` moves relative to SCL.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEV_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_WAIT_STOP
    } tgt_state_e;

    localparam logic [3:0] DEV_ID = 4'b1010;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Idle bus level is high on both lines.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = !scl_q && scl_s;
    assign scl_fall  = scl_q && !scl_s;
    assign start_det = scl_q && scl_s && sda_q && !sda_s;
    assign stop_det  = scl_q && scl_s && !sda_q && sda_s;

endmodule

// File: rtl/page_buffer.sv
module page_buffer #(
    parameter int PAGE_W = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clr,
    input  logic                               wr_en,
    input  logic [PAGE_W-1:0]                  wr_idx,
    input  logic [7:0]                         wr_data,
    output logic [(1<<PAGE_W)-1:0][7:0]        data_o,
    output logic [(1<<PAGE_W)-1:0]             mask_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
            mask_o <= '0;
        end else if (clr) begin
            mask_o <= '0;
        end else if (wr_en) begin
            data_o[wr_idx] <= wr_data;
            mask_o[wr_idx] <= 1'b1;
        end
    end

    // R5
    buf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mask_o == '0));

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               commit,
    input  logic [ADDR_W-PAGE_W-1:0]           page_base,
    input  logic [(1<<PAGE_W)-1:0][7:0]        page_data,
    input  logic [(1<<PAGE_W)-1:0]             page_mask,
    input  logic [ADDR_W-1:0]                  rd_addr,
    output logic [7:0]                         rd_data
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PAGE_N = 1 << PAGE_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'h00;
            end
        end else if (commit) begin
            for (int i = 0; i < PAGE_N; i++) begin
                if (page_mask[i]) begin
                    mem[{page_base, PAGE_W'(i)}] <= page_data[i];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import i2c_eeprom_pkg::*;
#(
    parameter int PAGE_W      = 4,
    parameter int BUSY_CYCLES = 500000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    input  logic dis_i,
    output logic sda_oe_o
);
    localparam int WORD_W = 8;
    localparam int HI_W   = 3;
    localparam int ADDR_W = WORD_W + HI_W;
    localparam int PAGE_N = 1 << PAGE_W;
    localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] BUSY_LOAD = CNT_W'(BUSY_CYCLES);

    tgt_state_e state, state_nxt;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [3:0]        bit_cnt;
    logic [7:0]        rx_sh;
    logic [7:0]        tx_sh;
    logic [ADDR_W-1:0] ptr;
    logic [CNT_W-1:0]  busy_cnt;
    logic              mack_q;
    logic [7:0]        rd_data;
    logic [PAGE_N-1:0][7:0] buf_data;
    logic [PAGE_N-1:0] buf_mask;

    logic fall_at8, dev_hit, buf_wr, buf_clr, commit;

    i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign fall_at8 = scl_fall && (bit_cnt == 4'd8);
    assign dev_hit  = (rx_sh[7:4] == DEV_ID) && (busy_cnt == '0);
    assign commit   = stop_det && !dis_i && (|buf_mask);
    assign buf_wr   = !dis_i && (state == ST_WDATA) && fall_at8 && !wp_i;
    assign buf_clr  = dis_i || start_det || commit ||
                      ((state == ST_WDATA) && fall_at8 && wp_i);

    page_buffer #(.PAGE_W(PAGE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
        .wr_idx(ptr[PAGE_W-1:0]), .wr_data(rx_sh),
        .data_o(buf_data), .mask_o(buf_mask)
    );

    eeprom_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .page_base(ptr[ADDR_W-1:PAGE_W]), .page_data(buf_data),
        .page_mask(buf_mask), .rd_addr(ptr), .rd_data(rd_data)
    );

    // Next-state logic
    always_comb begin
        state_nxt = state;
        if (dis_i) begin
            state_nxt = ST_IDLE;
        end else if (start_det) begin
            state_nxt = ST_DEVADDR;
        end else if (stop_det) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      ;
                ST_DEVADDR:   if (fall_at8) state_nxt = dev_hit ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall) state_nxt = rx_sh[0] ? ST_RDATA : ST_WORD;
                ST_WORD:      if (fall_at8) state_nxt = ST_WORD_ACK;
                ST_WORD_ACK:  if (scl_fall) state_nxt = ST_WDATA;
                ST_WDATA:     if (fall_at8) state_nxt = wp_i ? ST_IDLE : ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_nxt = ST_WDATA;
                ST_RDATA:     if (scl_fall && bit_cnt == 4'd7) state_nxt = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall) state_nxt = mack_q ? ST_RDATA : ST_WAIT_STOP;
                ST_WAIT_STOP: ;
                default:      state_nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Datapath: shifters, bit counter, pointer, busy window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            ptr      <= '0;
            busy_cnt <= '0;
            mack_q   <= 1'b0;
        end else begin
            if (commit)               busy_cnt <= BUSY_LOAD;
            else if (busy_cnt != '0)  busy_cnt <= busy_cnt - 1'b1;

            if (dis_i || start_det || stop_det) begin
                bit_cnt <= '0;
            end else begin
                case (state)
                    ST_DEVADDR, ST_WORD, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (fall_at8) begin
                            bit_cnt <= '0;
                            if (state == ST_DEVADDR && dev_hit)
                                ptr[ADDR_W-1:WORD_W] <= rx_sh[HI_W:1];
                            if (state == ST_WORD)
                                ptr[WORD_W-1:0] <= rx_sh;
                            if (state == ST_WDATA && !wp_i)
                                ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall && rx_sh[0]) begin
                            tx_sh <= rd_data;
                            ptr   <= ptr + 1'b1;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                bit_cnt <= '0;
                            end else begin
                                tx_sh   <= {tx_sh[6:0], 1'b0};
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) mack_q <= !sda_s;
                        if (scl_fall && mack_q) begin
                            tx_sh <= rd_data;
                            ptr   <= ptr + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_WORD_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
            ST_RDATA:                              sda_oe_o = !tx_sh[7];
            default:                               sda_oe_o = 1'b0;
        endcase
    end

    // R12
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe_o) && !$past(dis_i)) |-> !scl_s);

    // R6
    busy_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK && $past(state) == ST_DEVADDR) |-> ($past(busy_cnt) == '0));

    // R10
    wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA_ACK && $past(state) == ST_WDATA) |-> !$past(wp_i));

    // R11
    dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |=> (state == ST_IDLE && !sda_oe_o));

endmodule

// File: tb/i2c_eeprom_target_tb_top.sv
module i2c_eeprom_target_tb_top;
    localparam int BUSY = 400;
    localparam int Q    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic dis = 1'b0;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int viol = 0;
    logic prev_oe = 1'b0;

    logic [7:0] model_mem [2048];
    int mptr = 0;

    assign sda_line = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    i2c_eeprom_target #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .wp_i(wp), .dis_i(dis), .sda_oe_o(sda_oe)
    );

    // R12 monitor: every clock, the enable must not move while SCL is high
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && scl) viol++;
        prev_oe = sda_oe;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a, input int k);
        return 8'((a * 7 + k * 29 + 3) & 255);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_bit(input logic drv, output logic seen);
        idle(Q); m_sda = drv;
        idle(Q); scl = 1'b1;
        idle(Q); seen = sda_line;
        idle(Q); scl = 1'b0;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; idle(Q);
        scl = 1'b1;   idle(Q);
        m_sda = 1'b0; idle(Q);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; idle(Q);
        scl = 1'b1;   idle(Q);
        m_sda = 1'b1; idle(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            d[i] = s;
        end
        clock_bit(!mack, s);
    endtask

    task automatic write_burst(input logic [10:0] addr, input int n, input string req);
        logic a;
        logic [7:0] d;
        int base;
        int off;
        base = int'(addr) & ~15;
        bus_start();
        send_byte({4'b1010, addr[10:8], 1'b0}, a); check_eq(req, int'(a), 1);
        send_byte(addr[7:0], a);                   check_eq(req, int'(a), 1);
        for (int k = 0; k < n; k++) begin
            d = pat(int'(addr), k);
            send_byte(d, a); check_eq(req, int'(a), 1);
            off = ((int'(addr) & 15) + k) % 16;
            model_mem[base | off] = d;
        end
        bus_stop();
        mptr = base | (((int'(addr) & 15) + n) % 16);
    endtask

    task automatic read_random(input logic [10:0] addr, input int n, input string req,
                               input bit probe);
        logic a;
        logic s;
        logic [7:0] d;
        bus_start();
        send_byte({4'b1010, addr[10:8], 1'b0}, a); check_eq(req, int'(a), 1);
        send_byte(addr[7:0], a);                   check_eq(req, int'(a), 1);
        bus_start();
        send_byte({4'b1010, addr[10:8], 1'b1}, a); check_eq(req, int'(a), 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            check_eq(req, int'(d), int'(model_mem[(int'(addr) + k) % 2048]));
        end
        if (probe) begin
            // R9: after master NACK the line must stay released
            clock_bit(1'b1, s);
            check_eq("R9", int'(s), 1);
        end
        bus_stop();
        mptr = (int'(addr) + n) % 2048;
    endtask

    task automatic read_current(input int n, input string req);
        logic a;
        logic [7:0] d;
        logic [10:0] p;
        p = 11'(mptr);
        bus_start();
        send_byte({4'b1010, p[10:8], 1'b1}, a); check_eq(req, int'(a), 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            check_eq(req, int'(d), int'(model_mem[(mptr + k) % 2048]));
        end
        bus_stop();
        mptr = (mptr + n) % 2048;
    endtask

    task automatic poll(input int exp_ack, input string req);
        logic a;
        bus_start();
        send_byte(8'hA0, a);
        check_eq(req, int'(a), exp_ack);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        logic a;
        logic [7:0] d;
        for (int i = 0; i < 2048; i++) model_mem[i] = 8'h00;
        idle(5);
        rst_n = 1'b1;
        idle(5);

        // R13: reset state, pointer 0, array reads zero
        check_eq("R13", int'(sda_oe), 0);
        read_current(1, "R13");
        idle(20);

        // R1: byte clocked without START is ignored
        send_byte(8'hA0, a);
        check_eq("R1", int'(a), 0);
        bus_stop(); idle(20);

        // R2: wrong device id, then bus ignored
        bus_start();
        send_byte(8'hB0, a); check_eq("R2", int'(a), 0);
        send_byte(8'h12, a); check_eq("R2", int'(a), 0);
        bus_stop(); idle(20);

        // R3, R6: byte write, polling during and after busy window
        write_burst(11'h123, 1, "R3");
        poll(0, "R6");
        idle(BUSY + 60);
        poll(1, "R6");
        idle(20);
        // R8: random read of written byte
        read_random(11'h123, 1, "R8", 1'b0);
        idle(20);

        // R4: 18-byte burst wraps within the page; R9 probe after NACK
        write_burst(11'h245, 18, "R4");
        idle(BUSY + 60);
        read_random(11'h240, 16, "R4", 1'b1);
        idle(20);

        // R7: full-array wrap and current-address continuation
        write_burst(11'h7FF, 1, "R7");
        idle(BUSY + 60);
        write_burst(11'h000, 2, "R7");
        idle(BUSY + 60);
        read_random(11'h7FE, 4, "R7", 1'b0);
        read_current(1, "R7");
        idle(20);

        // R10: write protect refuses data, no busy window
        wp = 1'b1;
        bus_start();
        send_byte(8'hA2, a);                       check_eq("R10", int'(a), 1);
        send_byte(8'h23, a);                       check_eq("R10", int'(a), 1);
        send_byte(~model_mem[11'h123], a);         check_eq("R10", int'(a), 0);
        bus_stop();
        wp = 1'b0;
        poll(1, "R10");
        read_random(11'h123, 1, "R10", 1'b0);
        idle(20);

        // R11: disabled target gives no acknowledge
        dis = 1'b1;
        idle(4);
        bus_start();
        send_byte(8'hA2, a); check_eq("R11", int'(a), 0);
        bus_stop();
        idle(4);
        dis = 1'b0;
        idle(10);
        // R11: disable mid-write discards the buffer
        bus_start();
        send_byte(8'hA2, a);               check_eq("R11", int'(a), 1);
        send_byte(8'h23, a);               check_eq("R11", int'(a), 1);
        send_byte(~model_mem[11'h123], a); check_eq("R11", int'(a), 1);
        dis = 1'b1; idle(3); dis = 1'b0;
        bus_stop();
        poll(1, "R11");
        read_random(11'h123, 1, "R11", 1'b0);
        idle(20);

        // R5: repeated START discards buffered bytes, read continues at pointer
        bus_start();
        send_byte(8'hA4, a); check_eq("R5", int'(a), 1);
        send_byte(8'h45, a); check_eq("R5", int'(a), 1);
        send_byte(~model_mem[11'h245], a); check_eq("R5", int'(a), 1);
        send_byte(~model_mem[11'h246], a); check_eq("R5", int'(a), 1);
        bus_start();
        send_byte(8'hA5, a); check_eq("R5", int'(a), 1);
        recv_byte(1'b0, d);
        check_eq("R5", int'(d), int'(model_mem[11'h247]));
        bus_stop();
        poll(1, "R5");
        read_random(11'h245, 2, "R5", 1'b0);
        idle(20);

        // R12: enable only moved while SCL low
        check_eq("R12", viol, 0);

        finish_run();
    end

endmodule